// File: doc/BRIEF.md
# Flow-Through Burst Static Memory

A single-port synchronous word memory with a 36-bit data path, split into four 9-bit byte lanes, and a depth set by a parameter. Each rising clock edge samples the address, the write data and every control input. A load from either of two address strobes, the processor-side strobe or the controller-side strobe, captures a new address and starts a burst. After that, an advance input steps a 2-bit beat counter through the other three words of the aligned four-word block. The order of those words is linear or interleaved, chosen when the burst starts. Read data is flow-through: the word at the address held in the register appears on the output as combinational logic after the edge. No output register is placed in the path, so a burst delivers one word per clock after its first access.

Writes use the address that the same edge selects. A global write stores all four lanes. Otherwise each lane is stored only when the byte-write master enable and that lane's own enable are both high. The output enable acts without the clock: when it is low the output is forced to zero. A strobe with the chip enable low deselects the memory. Writes are then ignored and the output stays zero until a strobe selects the memory again. The memory takes one access every cycle and applies no back-pressure, so the pins have no valid/ready pair.

Top module: `flowthru_burst_sram`

## Requirements
- R1: During and after reset, with no strobe yet seen, the memory is deselected and `rd_data` is all zeros.
- R2: A rising edge with `strb_cpu` or `strb_ctl` high loads the address from `addr_in`. If `chip_sel` is high, the word at that address is on `rd_data` once the edge has passed, with no further cycle of delay.
- R3: With burst order linear (`ilv_mode` low when the burst started), each edge with `adv` high and no strobe gives low address bits equal to (start + beat) mod 4.
- R4: With `ilv_mode` high when the burst started, the low address bits on beat k are start XOR k.
- R5: A burst wraps inside its aligned four-word block. The address bits above bit 1 do not change until the next strobe, even after more than four beats.
- R6: An edge with no strobe and `adv` low holds the address, so the same word stays on `rd_data`.
- R7: When a strobe and `adv` are high on the same edge, the strobe wins and the new address is loaded.
- R8: `wr_global` high writes all 36 bits of `wr_data` into the addressed word, whatever the lane enables are.
- R9: With `wr_global` low and `wr_bytes` high, lane i (bits 9i+8 down to 9i) is written only when `wr_lane[i]` is high. The other lanes keep their contents.
- R10: With `wr_global` and `wr_bytes` both low, the lane enables have no effect on the stored word.
- R11: `out_en` low forces `rd_data` to zero at once, including in the middle of a cycle.
- R12: A strobe with `chip_sel` low deselects the memory. Later writes are ignored and `rd_data` is zero until a strobe with `chip_sel` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | ADDR_W | Word address, loaded on a strobe |
| strb_cpu | input | 1 | Processor-side address strobe, active high |
| strb_ctl | input | 1 | Controller-side address strobe, active high |
| adv | input | 1 | Steps the burst beat when no strobe is high |
| ilv_mode | input | 1 | Burst order sampled at a strobe: 1 interleaved, 0 linear |
| chip_sel | input | 1 | Chip enable, sampled at a strobe |
| wr_global | input | 1 | Write all four lanes |
| wr_bytes | input | 1 | Master enable for per-lane writes |
| wr_lane | input | 4 | Per-lane write enables |
| wr_data | input | 36 | Write data, four 9-bit lanes |
| out_en | input | 1 | Output enable, combinational; low forces zero |
| rd_data | output | 36 | Flow-through read data |

## Verification
A write and a flow-through read can fall in the same cycle. The edge that selects an address also stores into that word, and the output just after the edge must already show the merged word. The bench provokes this with strobe-plus-write cycles and with partial lane writes during a burst. A reference model checks each result: it applies the lane merge before it predicts the output. A second overlap is a strobe and `adv` high together. Both are driven high on the same edge, and the word checked is the newly loaded one, not the next beat.

// File: rtl/fts_pkg.sv
package fts_pkg;
  localparam int LANES    = 4;
  localparam int LANE_W   = 9;
  localparam int WORD_W   = LANES * LANE_W;
  localparam int BEAT_W   = 2;

  typedef logic [BEAT_W-1:0] beat_t;

  // low address bits for a beat, given the start bits and the order
  function automatic beat_t beat_low(input beat_t start, input beat_t beat, input logic ilv);
    beat_t r;
    if (ilv) r = start ^ beat;
    else     r = start + beat;
    return r;
  endfunction
endpackage

// File: rtl/fts_addr_unit.sv
module fts_addr_unit
  import fts_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              load,
  input  logic              adv,
  input  logic              ilv_in,
  input  logic              sel_in,
  output logic [ADDR_W-1:0] nxt_addr,
  output logic              nxt_act,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              act_q,
  output logic              ilv_q
);
  localparam int BASE_W = ADDR_W - BEAT_W;

  logic [BASE_W-1:0] base_q, base_d;
  beat_t             start_q, start_d;
  beat_t             beat_q, beat_d;
  logic              ilv_d, act_d;

  always_comb begin
    base_d  = base_q;
    start_d = start_q;
    beat_d  = beat_q;
    ilv_d   = ilv_q;
    act_d   = act_q;
    if (load) begin
      base_d  = addr_in[ADDR_W-1:BEAT_W];
      start_d = addr_in[BEAT_W-1:0];
      beat_d  = '0;
      ilv_d   = ilv_in;
      act_d   = sel_in;
    end else if (adv) begin
      beat_d  = beat_q + beat_t'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      start_q <= '0;
      beat_q  <= '0;
      ilv_q   <= 1'b0;
      act_q   <= 1'b0;
    end else begin
      base_q  <= base_d;
      start_q <= start_d;
      beat_q  <= beat_d;
      ilv_q   <= ilv_d;
      act_q   <= act_d;
    end
  end

  assign nxt_addr = {base_d, beat_low(start_d, beat_d, ilv_d)};
  assign nxt_act  = act_d;
  assign cur_addr = {base_q, beat_low(start_q, beat_q, ilv_q)};
endmodule

// File: rtl/fts_lane_ctl.sv
module fts_lane_ctl
  import fts_pkg::*;
(
  input  logic             act,
  input  logic             wr_global,
  input  logic             wr_bytes,
  input  logic [LANES-1:0] wr_lane,
  output logic [LANES-1:0] lane_we
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_we[l] = act & (wr_global | (wr_bytes & wr_lane[l]));
  end
endmodule

// File: rtl/fts_store.sv
module fts_store
  import fts_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic [LANES-1:0]  lane_we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rword
);
  for (genvar l = 0; l < LANES; l++) begin : g_bank
    logic [LANE_W-1:0] bank [DEPTH];
    always_ff @(posedge clk) begin
      if (lane_we[l]) bank[waddr] <= wdata[l*LANE_W +: LANE_W];
    end
    assign rword[l*LANE_W +: LANE_W] = bank[raddr];
  end
endmodule

// File: rtl/flowthru_burst_sram.sv
module flowthru_burst_sram
  import fts_pkg::*;
#(
  parameter int DEPTH_WORDS = 256,
  localparam int ADDR_W     = $clog2(DEPTH_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              strb_cpu,
  input  logic              strb_ctl,
  input  logic              adv,
  input  logic              ilv_mode,
  input  logic              chip_sel,
  input  logic              wr_global,
  input  logic              wr_bytes,
  input  logic [3:0]        wr_lane,
  input  logic [35:0]       wr_data,
  input  logic              out_en,
  output logic [35:0]       rd_data
);
  logic              load;
  logic [ADDR_W-1:0] nxt_addr, cur_addr;
  logic              nxt_act, act_q, ilv_q;
  logic [LANES-1:0]  lane_we;
  logic [WORD_W-1:0] rword;

  assign load = strb_cpu | strb_ctl;

  fts_addr_unit #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .load(load), .adv(adv),
    .ilv_in(ilv_mode), .sel_in(chip_sel), .nxt_addr(nxt_addr), .nxt_act(nxt_act),
    .cur_addr(cur_addr), .act_q(act_q), .ilv_q(ilv_q)
  );

  fts_lane_ctl u_lane (
    .act(nxt_act), .wr_global(wr_global), .wr_bytes(wr_bytes),
    .wr_lane(wr_lane), .lane_we(lane_we)
  );

  fts_store #(.DEPTH(DEPTH_WORDS), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .lane_we(lane_we), .waddr(nxt_addr), .wdata(wr_data),
    .raddr(cur_addr), .rword(rword)
  );

  assign rd_data = (out_en && act_q) ? rword : '0;
endmodule

// File: rtl/fts_sram_chk.sv
module fts_sram_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              strb_cpu,
  input logic              strb_ctl,
  input logic              adv,
  input logic              chip_sel,
  input logic              out_en,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              act_q,
  input logic              ilv_q,
  input logic [35:0]       rd_data
);
  logic any_strb;
  assign any_strb = strb_cpu | strb_ctl;

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    any_strb |=> cur_addr == $past(addr_in));

  assert_lin_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_strb && adv && !ilv_q) |=> cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1);

  assert_block_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !any_strb |=> cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2]));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_strb && !adv) |=> $stable(cur_addr));

  assert_oe_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> rd_data == 36'd0);

  assert_desel_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (any_strb && !chip_sel) |=> (!act_q && rd_data == 36'd0));
endmodule

bind flowthru_burst_sram fts_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .strb_cpu(strb_cpu), .strb_ctl(strb_ctl), .adv(adv),
  .chip_sel(chip_sel), .out_en(out_en), .addr_in(addr_in), .cur_addr(cur_addr),
  .act_q(act_q), .ilv_q(ilv_q), .rd_data(rd_data)
);

// File: tb/flowthru_burst_sram_test.sv
`timescale 1ns/1ps
module flowthru_burst_sram_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr_in = '0;
  logic        strb_cpu = 0, strb_ctl = 0, adv = 0, ilv_mode = 0, chip_sel = 0;
  logic        wr_global = 0, wr_bytes = 0, out_en = 1;
  logic [3:0]  wr_lane = '0;
  logic [35:0] wr_data = '0;
  logic [35:0] rd_data;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  flowthru_burst_sram #(.DEPTH_WORDS(256)) uut (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .strb_cpu(strb_cpu), .strb_ctl(strb_ctl),
    .adv(adv), .ilv_mode(ilv_mode), .chip_sel(chip_sel), .wr_global(wr_global),
    .wr_bytes(wr_bytes), .wr_lane(wr_lane), .wr_data(wr_data), .out_en(out_en),
    .rd_data(rd_data)
  );

  // reference model state
  bit [35:0] ref_mem [256];
  bit        ref_known [256];
  bit [5:0]  rb;
  bit [1:0]  rs, rk;
  bit        ri, ra;

  logic [35:0] exp_q [$];
  string       tag_q [$];

  task automatic check(input logic [35:0] act, input logic [35:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: rd_data=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      check(rd_data, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  function automatic bit [35:0] pat(input int i);
    return {9'(i + 9'h40), 9'(i + 9'h80), 9'(i + 9'h100), 9'(i)};
  endfunction

  // driver: one clock edge with given inputs; pushes the expected output
  task automatic step(input bit scpu, input bit sctl, input bit adv_v, input bit ilv_v,
                      input bit sel_v, input bit gw_v, input bit bwe_v, input bit [3:0] ln,
                      input bit [35:0] wd, input bit [7:0] a, input bit oe_v, input string tag);
    bit [7:0]  ad;
    bit [35:0] e;
    bit        push;
    @(negedge clk); #0.5;
    strb_cpu = scpu; strb_ctl = sctl; adv = adv_v; ilv_mode = ilv_v; chip_sel = sel_v;
    wr_global = gw_v; wr_bytes = bwe_v; wr_lane = ln; wr_data = wd; addr_in = a; out_en = oe_v;
    if (scpu || sctl) begin
      rb = a[7:2]; rs = a[1:0]; rk = 2'd0; ri = ilv_v; ra = sel_v;
    end else if (adv_v) begin
      rk = rk + 2'd1;
    end
    ad = {rb, (ri ? (rs ^ rk) : (rs + rk))};
    if (ra) begin
      if (gw_v) begin
        ref_mem[ad] = wd; ref_known[ad] = 1;
      end else if (bwe_v) begin
        for (int l = 0; l < 4; l++)
          if (ln[l]) ref_mem[ad][l*9 +: 9] = wd[l*9 +: 9];
      end
    end
    push = 1;
    if (oe_v && ra) begin
      e = ref_mem[ad];
      if (!ref_known[ad]) push = 0;
    end else begin
      e = '0;
    end
    @(posedge clk);
    if (push) begin
      exp_q.push_back(e);
      tag_q.push_back(tag);
    end
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 4'h0, 36'h0, 8'h0, 1, tag);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #100000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      summary();
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin ref_mem[i] = '0; ref_known[i] = 0; end
    rb = '0; rs = '0; rk = '0; ri = 0; ra = 0;
    #12;
    // R1: output idle while in reset and just after it
    check(rd_data, 36'h0, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(rd_data, 36'h0, "R1 after reset");

    // R8 R2: global writes, controller strobe, flow-through read of the written word
    for (int i = 8'h10; i < 8'h14; i++)
      step(0, 1, 0, 0, 1, 1, 1, 4'h0, pat(i), 8'(i), 1, "R8 R2 global write");
    for (int i = 8'h20; i < 8'h24; i++)
      step(1, 0, 0, 0, 1, 1, 0, 4'h5, pat(i), 8'(i), 1, "R8 R2 global write cpu strobe");

    // R3 R5: linear burst from 0x11, runs past four beats and wraps
    step(1, 0, 0, 0, 1, 0, 0, 4'h0, 36'h0, 8'h11, 1, "R2 load 0x11");
    for (int k = 0; k < 5; k++)
      step(0, 0, 1, 0, 0, 0, 0, 4'h0, 36'h0, 8'hff, 1, "R3 R5 linear beat");

    // R4: interleaved burst from 0x11 -> 11,10,13,12
    step(0, 1, 0, 1, 1, 0, 0, 4'h0, 36'h0, 8'h11, 1, "R4 load ilv");
    for (int k = 0; k < 4; k++)
      step(0, 0, 1, 1, 1, 0, 0, 4'h0, 36'h0, 8'h33, 1, "R4 R5 interleaved beat");

    // R6: hold
    step(0, 0, 0, 0, 0, 0, 0, 4'h0, 36'h0, 8'h22, 1, "R6 hold");
    step(0, 0, 0, 0, 0, 0, 0, 4'h0, 36'h0, 8'h22, 1, "R6 hold");

    // R7: strobe and advance together
    step(0, 1, 1, 0, 1, 0, 0, 4'h0, 36'h0, 8'h22, 1, "R7 strobe over adv");
    step(0, 0, 1, 0, 1, 0, 0, 4'h0, 36'h0, 8'h22, 1, "R7 next beat");

    // R9: lane writes on load and during a burst
    step(1, 0, 0, 0, 1, 0, 1, 4'h5, 36'h1_2345_6789, 8'h12, 1, "R9 lanes 0,2");
    step(0, 0, 1, 0, 1, 0, 1, 4'ha, 36'h9_8765_4321, 8'h00, 1, "R9 lanes 1,3 in burst");
    step(0, 1, 0, 0, 1, 0, 0, 4'h0, 36'h0, 8'h12, 1, "R9 reread 0x12");
    step(0, 0, 1, 0, 1, 0, 0, 4'h0, 36'h0, 8'h12, 1, "R9 reread 0x13");

    // R10: lane enables without master or global
    step(1, 0, 0, 0, 1, 0, 0, 4'hf, 36'hf_ffff_ffff, 8'h20, 1, "R10 no write");
    step(0, 0, 0, 0, 1, 0, 0, 4'hf, 36'hf_ffff_ffff, 8'h20, 1, "R10 still unchanged");

    // R11: output enable low, sampled and mid-cycle
    step(1, 0, 0, 0, 1, 0, 0, 4'h0, 36'h0, 8'h21, 0, "R11 oe low");
    idle("R11 back on");
    @(negedge clk); #1;
    out_en = 1'b0; #0.5;
    check(rd_data, 36'h0, "R11 async oe low");
    out_en = 1'b1; #0.5;
    check(rd_data, ref_mem[8'h21], "R11 async oe high");

    // R12: deselect ignores writes, reselect shows old word
    step(0, 1, 0, 0, 0, 1, 1, 4'hf, 36'h0_dead_beef, 8'h10, 1, "R12 deselect write");
    step(0, 0, 1, 0, 0, 1, 0, 4'h0, 36'h0_dead_beef, 8'h10, 1, "R12 deselected adv write");
    step(1, 0, 0, 0, 1, 0, 0, 4'h0, 36'h0, 8'h10, 1, "R12 reselect 0x10");
    step(0, 0, 1, 0, 1, 0, 0, 4'h0, 36'h0, 8'h10, 1, "R12 reselect 0x11");
    idle("final");
    idle("final");
    @(negedge clk); #1;
    finished = 1;
    summary();
  end
endmodule